// File: doc/BRIEF.md
# Register-Offset Halfword and Signed Load/Store Unit

This unit executes one slot of a 16-bit compressed instruction set: the register-offset memory operations that move halfwords or load sign-extended bytes and halfwords. A sequencer presents an instruction with a one-cycle `start` strobe. The unit then names the three registers it needs on the register-file read selects. It forms the effective address by adding two of them and issues exactly one request on a simple request/acknowledge memory port. When the memory acknowledges, the unit returns the extended load value for writeback and the base cycle cost of the operation.

An instruction that does not belong to this slot is refused with a one-cycle `unhandled` pulse. A refused instruction causes no memory traffic and no writeback. Wait states, rotation of misaligned data and every other instruction format are left to the neighbouring logic.

Top module: `rofs_hls_unit`

## Requirements
- R1: After a synchronous reset, `busy`, `mem_req`, `mem_we`, `done`, `wb_en` and `unhandled` are all 0.
- R2: `mem_addr` equals, modulo 2^32, the sum of the register selected by instruction bits 5:3 and the register selected by bits 8:6; `rf_sel_base` carries bits 5:3 and `rf_sel_off` carries bits 8:6.
- R3: The unit accepts an instruction when bits 15:12 are 0101 and bit 9 is 1. Bits 11:10 then pick the operation: 00 stores a halfword, 01 loads a signed byte, 10 loads an unsigned halfword, 11 loads a signed halfword. `mem_size` is 0 for a byte and 1 for a halfword. `mem_we` is 1 only for the store.
- R4: A store drives `mem_wdata` with bits 15:0 of the register selected by instruction bits 2:0 (`rf_sel_data`) and zeros above.
- R5: A signed byte load returns `mem_rdata[7:0]` with bit 7 copied into bits 31:8.
- R6: An unsigned halfword load returns `mem_rdata[15:0]` with bits 31:16 cleared.
- R7: A signed halfword load returns `mem_rdata[15:0]` with bit 15 copied into bits 31:16.
- R8: With `done`, the cost outputs give the base cycles. A store gives n=2, s=0, i=0. Each load gives n=1, s=1, i=1.
- R9: Each accepted instruction raises `mem_req` exactly once. The request stays high with a stable address until a cycle where `mem_ack` is 1, and it is low in the following cycle.
- R10: `done` is a one-cycle pulse in the cycle after the acknowledged request. `wb_en` is 1 only with `done` and only for loads, and `wb_sel` then equals instruction bits 2:0.
- R11: A strobed instruction outside the slot gives `unhandled` for one cycle in the cycle after `start`, and produces no request and no `done`.
- R12: `start` is ignored while `busy` is 1: no second request follows, and the result belongs to the first instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Instruction strobe |
| instr | input | 16 | Instruction word, sampled with `start` |
| busy | output | 1 | An accepted instruction is in progress |
| rf_sel_base | output | 3 | Register-file select for the base register |
| rf_sel_off | output | 3 | Register-file select for the offset register |
| rf_sel_data | output | 3 | Register-file select for the store data register |
| rf_base_val | input | 32 | Value of the register named by `rf_sel_base` |
| rf_off_val | input | 32 | Value of the register named by `rf_sel_off` |
| rf_data_val | input | 32 | Value of the register named by `rf_sel_data` |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_size | output | 2 | Access size: 0 byte, 1 halfword |
| mem_addr | output | 32 | Effective address |
| mem_wdata | output | 32 | Store data |
| mem_ack | input | 1 | Memory acknowledge, counted only while `mem_req` is 1 |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| done | output | 1 | One-cycle completion pulse |
| wb_en | output | 1 | Register writeback enable |
| wb_sel | output | 3 | Writeback register index |
| wb_data | output | 32 | Extended load value |
| cost_n | output | 2 | Non-sequential base cycles |
| cost_s | output | 2 | Sequential base cycles |
| cost_i | output | 2 | Internal base cycles |
| unhandled | output | 1 | Instruction refused |

## Verification
If `start` is sampled at edge k, `mem_req`, `mem_addr` and the store data appear after edge k+1. They stay unchanged through any number of wait cycles. `done`, the writeback fields and the costs appear after the edge that samples `mem_ack`, and `unhandled` appears after edge k itself. The bench drives every input at a falling edge and reads each result at the falling edge that follows the rising edge where it becomes due. It also checks, one falling edge later, that pulses have dropped and no further request has started.

// File: rtl/rofs_pkg.sv
package rofs_pkg;

  typedef enum logic [1:0] {
    OP_ST_HALF  = 2'b00,
    OP_LD_SBYTE = 2'b01,
    OP_LD_UHALF = 2'b10,
    OP_LD_SHALF = 2'b11
  } rofs_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1
  } rofs_size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_ISSUE = 2'd2
  } rofs_state_e;

  localparam logic [3:0] GROUP_TAG = 4'b0101;

endpackage

// File: rtl/rofs_decode.sv
module rofs_decode
  import rofs_pkg::*;
#(
  parameter int INSTR_W = 16,
  parameter int SEL_W   = 3,
  parameter int COST_W  = 2
) (
  input  logic [INSTR_W-1:0] instr,
  output logic               handled,
  output rofs_op_e           op,
  output logic               is_load,
  output logic [1:0]         size,
  output logic [SEL_W-1:0]   sel_data,
  output logic [SEL_W-1:0]   sel_base,
  output logic [SEL_W-1:0]   sel_off,
  output logic [COST_W-1:0]  cost_n,
  output logic [COST_W-1:0]  cost_s,
  output logic [COST_W-1:0]  cost_i
);
  localparam int OP_LO  = 3 * SEL_W + 1;
  localparam int SLOT_B = 3 * SEL_W;

  assign sel_data = instr[SEL_W-1:0];
  assign sel_base = instr[2*SEL_W-1:SEL_W];
  assign sel_off  = instr[3*SEL_W-1:2*SEL_W];
  assign op       = rofs_op_e'(instr[OP_LO+1:OP_LO]);
  assign handled  = (instr[INSTR_W-1:INSTR_W-4] == GROUP_TAG) && instr[SLOT_B];
  assign is_load  = (op != OP_ST_HALF);

  always_comb begin
    unique case (op)
      OP_ST_HALF: begin
        size   = SZ_HALF;
        cost_n = COST_W'(2);
        cost_s = '0;
        cost_i = '0;
      end
      OP_LD_SBYTE: begin
        size   = SZ_BYTE;
        cost_n = COST_W'(1);
        cost_s = COST_W'(1);
        cost_i = COST_W'(1);
      end
      default: begin
        size   = SZ_HALF;
        cost_n = COST_W'(1);
        cost_s = COST_W'(1);
        cost_i = COST_W'(1);
      end
    endcase
  end
endmodule

// File: rtl/rofs_agu.sv
module rofs_agu #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] base_val,
  input  logic [DATA_W-1:0] off_val,
  output logic [DATA_W-1:0] addr
);
  assign addr = base_val + off_val;
endmodule

// File: rtl/rofs_extend.sv
module rofs_extend
  import rofs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  rofs_op_e          op,
  input  logic [DATA_W-1:0] raw,
  output logic [DATA_W-1:0] ext
);
  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;

  always_comb begin
    unique case (op)
      OP_LD_SBYTE: ext = {{(DATA_W-BYTE_W){raw[BYTE_W-1]}}, raw[BYTE_W-1:0]};
      OP_LD_SHALF: ext = {{(DATA_W-HALF_W){raw[HALF_W-1]}}, raw[HALF_W-1:0]};
      OP_LD_UHALF: ext = {{(DATA_W-HALF_W){1'b0}}, raw[HALF_W-1:0]};
      default:     ext = '0;
    endcase
  end
endmodule

// File: rtl/rofs_hls_unit.sv
module rofs_hls_unit
  import rofs_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int INSTR_W = 16,
  parameter int SEL_W   = 3,
  parameter int COST_W  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [INSTR_W-1:0] instr,
  output logic               busy,
  output logic [SEL_W-1:0]   rf_sel_base,
  output logic [SEL_W-1:0]   rf_sel_off,
  output logic [SEL_W-1:0]   rf_sel_data,
  input  logic [DATA_W-1:0]  rf_base_val,
  input  logic [DATA_W-1:0]  rf_off_val,
  input  logic [DATA_W-1:0]  rf_data_val,
  output logic               mem_req,
  output logic               mem_we,
  output logic [1:0]         mem_size,
  output logic [DATA_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic               mem_ack,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               done,
  output logic               wb_en,
  output logic [SEL_W-1:0]   wb_sel,
  output logic [DATA_W-1:0]  wb_data,
  output logic [COST_W-1:0]  cost_n,
  output logic [COST_W-1:0]  cost_s,
  output logic [COST_W-1:0]  cost_i,
  output logic               unhandled
);
  localparam int HALF_W = 16;

  rofs_state_e        state;
  logic [INSTR_W-1:0] instr_q;

  // Decode of the incoming word, used only for acceptance.
  logic             in_handled;
  rofs_op_e         in_op;
  logic             in_is_load;
  logic [1:0]       in_size;
  logic [SEL_W-1:0] in_sd, in_sb, in_so;
  logic [COST_W-1:0] in_cn, in_cs, in_ci;

  rofs_decode #(.INSTR_W(INSTR_W), .SEL_W(SEL_W), .COST_W(COST_W)) u_dec_in (
    .instr(instr), .handled(in_handled), .op(in_op), .is_load(in_is_load),
    .size(in_size), .sel_data(in_sd), .sel_base(in_sb), .sel_off(in_so),
    .cost_n(in_cn), .cost_s(in_cs), .cost_i(in_ci)
  );

  // Decode of the held word, drives the datapath.
  logic              q_handled;
  rofs_op_e          q_op;
  logic              q_is_load;
  logic [1:0]        q_size;
  logic [SEL_W-1:0]  q_sd, q_sb, q_so;
  logic [COST_W-1:0] q_cn, q_cs, q_ci;

  rofs_decode #(.INSTR_W(INSTR_W), .SEL_W(SEL_W), .COST_W(COST_W)) u_dec_q (
    .instr(instr_q), .handled(q_handled), .op(q_op), .is_load(q_is_load),
    .size(q_size), .sel_data(q_sd), .sel_base(q_sb), .sel_off(q_so),
    .cost_n(q_cn), .cost_s(q_cs), .cost_i(q_ci)
  );

  logic [DATA_W-1:0] agu_addr;
  logic [DATA_W-1:0] ext_val;

  rofs_agu #(.DATA_W(DATA_W)) u_agu (
    .base_val(rf_base_val), .off_val(rf_off_val), .addr(agu_addr)
  );

  rofs_extend #(.DATA_W(DATA_W)) u_ext (
    .op(q_op), .raw(mem_rdata), .ext(ext_val)
  );

  assign rf_sel_base = q_sb;
  assign rf_sel_off  = q_so;
  assign rf_sel_data = q_sd;
  assign busy        = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      instr_q   <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_size  <= 2'd0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      done      <= 1'b0;
      wb_en     <= 1'b0;
      wb_sel    <= '0;
      wb_data   <= '0;
      cost_n    <= '0;
      cost_s    <= '0;
      cost_i    <= '0;
      unhandled <= 1'b0;
    end else begin
      done      <= 1'b0;
      wb_en     <= 1'b0;
      unhandled <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            if (in_handled) begin
              instr_q <= instr;
              state   <= ST_FETCH;
            end else begin
              unhandled <= 1'b1;
            end
          end
        end
        ST_FETCH: begin
          mem_req   <= 1'b1;
          mem_addr  <= agu_addr;
          mem_we    <= ~q_is_load;
          mem_size  <= q_size;
          mem_wdata <= q_is_load ? '0
                       : {{(DATA_W-HALF_W){1'b0}}, rf_data_val[HALF_W-1:0]};
          state     <= ST_ISSUE;
        end
        ST_ISSUE: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            done    <= 1'b1;
            wb_en   <= q_is_load;
            wb_sel  <= q_sd;
            wb_data <= ext_val;
            cost_n  <= q_cn;
            cost_s  <= q_cs;
            cost_i  <= q_ci;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R9
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_req);

  // R10
  done_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(mem_req && mem_ack));

  // R10
  wb_only_done_chk: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> done);

  // R11
  unhandled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    unhandled |-> (!mem_req && !done && !busy));

  // R3
  store_half_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_size == 2'd1));

endmodule

// File: tb/tb_rofs_hls_unit.sv
module tb_rofs_hls_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] instr = '0;
  logic        busy;
  logic [2:0]  rf_sel_base, rf_sel_off, rf_sel_data;
  logic [31:0] rf_base_val, rf_off_val, rf_data_val;
  logic        mem_req, mem_we;
  logic [1:0]  mem_size;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done, wb_en;
  logic [2:0]  wb_sel;
  logic [31:0] wb_data;
  logic [1:0]  cost_n, cost_s, cost_i;
  logic        unhandled;

  logic [31:0] regs [8];
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign rf_base_val = regs[rf_sel_base];
  assign rf_off_val  = regs[rf_sel_off];
  assign rf_data_val = regs[rf_sel_data];

  rofs_hls_unit dut (
    .clk(clk), .rst(rst), .start(start), .instr(instr), .busy(busy),
    .rf_sel_base(rf_sel_base), .rf_sel_off(rf_sel_off), .rf_sel_data(rf_sel_data),
    .rf_base_val(rf_base_val), .rf_off_val(rf_off_val), .rf_data_val(rf_data_val),
    .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .done(done), .wb_en(wb_en), .wb_sel(wb_sel), .wb_data(wb_data),
    .cost_n(cost_n), .cost_s(cost_s), .cost_i(cost_i), .unhandled(unhandled)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pattern(input logic [31:0] a);
    return a * 32'h9E37_79B1 + 32'h0F0F_8181;
  endfunction

  function automatic logic [31:0] expect_load(input logic [1:0] op, input logic [31:0] p);
    case (op)
      2'b01:   return {{24{p[7]}}, p[7:0]};   // R5
      2'b10:   return {16'h0000, p[15:0]};    // R6
      2'b11:   return {{16{p[15]}}, p[15:0]}; // R7
      default: return 32'h0;
    endcase
  endfunction

  task automatic run_one(input logic [1:0] op, input logic [2:0] b, input logic [2:0] o,
                         input logic [2:0] d, input int waits, input bit poke);
    logic [31:0] ea;
    logic [31:0] p;
    bit ld;
    ld = (op != 2'b00);
    ea = regs[b] + regs[o];
    p  = pattern(ea);
    @(negedge clk);
    start = 1'b1;
    instr = {4'b0101, op, 1'b1, o, b, d};
    @(negedge clk);
    start = 1'b0;
    chk("R9 no request during register read", {31'b0, mem_req}, 32'd0);
    @(negedge clk);
    chk("R9 request raised", {31'b0, mem_req}, 32'd1);
    chk("R2 address", mem_addr, ea);
    chk("R3 write enable", {31'b0, mem_we}, {31'b0, ~ld});
    chk("R3 size", {30'b0, mem_size}, (op == 2'b01) ? 32'd0 : 32'd1);
    if (!ld) chk("R4 store data", mem_wdata, {16'h0000, regs[d][15:0]});
    for (int w = 0; w < waits; w++) begin
      if (poke && w == 0) begin
        start = 1'b1;
        instr = {4'b0101, ~op, 1'b1, ~o, ~b, ~d};
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      chk("R9 request held", {31'b0, mem_req}, 32'd1);
      chk("R12 address kept", mem_addr, ea);
    end
    start     = 1'b0;
    mem_ack   = 1'b1;
    mem_rdata = p;
    @(negedge clk);
    mem_ack   = 1'b0;
    mem_rdata = 32'hDEAD_BEEF;
    chk("R10 done pulse", {31'b0, done}, 32'd1);
    chk("R9 request dropped", {31'b0, mem_req}, 32'd0);
    chk("R10 writeback enable", {31'b0, wb_en}, {31'b0, ld});
    if (ld) begin
      chk("R10 writeback index", {29'b0, wb_sel}, {29'b0, d});
      chk("R5 R6 R7 load value", wb_data, expect_load(op, p));
    end
    chk("R8 cost n", {30'b0, cost_n}, ld ? 32'd1 : 32'd2);
    chk("R8 cost s", {30'b0, cost_s}, ld ? 32'd1 : 32'd0);
    chk("R8 cost i", {30'b0, cost_i}, ld ? 32'd1 : 32'd0);
    @(negedge clk);
    chk("R10 done single cycle", {31'b0, done}, 32'd0);
    chk("R12 no second request", {30'b0, mem_req, busy}, 32'd0);
  endtask

  task automatic run_foreign(input logic [15:0] w);
    @(negedge clk);
    start = 1'b1;
    instr = w;
    @(negedge clk);
    start = 1'b0;
    chk("R11 refused pulse", {31'b0, unhandled}, 32'd1);
    chk("R11 no request", {30'b0, mem_req, busy}, 32'd0);
    @(negedge clk);
    chk("R11 pulse ends", {31'b0, unhandled}, 32'd0);
    @(negedge clk);
    chk("R11 no done", {30'b0, done, mem_req}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) regs[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1
    chk("R1 reset outputs", {26'b0, busy, mem_req, mem_we, done, wb_en, unhandled}, 32'd0);
    for (int seed = 0; seed < 2; seed++) begin
      for (int i = 0; i < 8; i++)
        regs[i] = (32'h1357_9BDF * (i + 1)) ^ (seed ? 32'hFFFF_0000 : 32'h0000_8080);
      for (int op = 0; op < 4; op++)
        for (int b = 0; b < 8; b++)
          for (int o = 0; o < 8; o++)
            for (int d = 0; d < 8; d += 3)
              run_one(op[1:0], b[2:0], o[2:0], d[2:0], (b + o + d) % 4, (o == 2));
    end
    // R11: bit 9 clear, and foreign top bits
    run_foreign(16'b0101_0000_1111_1111);
    run_foreign(16'b0101_1101_1010_0101);
    run_foreign(16'hC0FF);
    run_foreign(16'h0000);
    run_foreign(16'h7E00);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule